// File: doc/BRIEF.md
# Perturb-and-Observe Duty Controller

This block steers a flyback stage so that a small group of photovoltaic cells (a pixel) delivers its maximum power, and it drives the stage's power switch directly. Each sample strobe brings three fixed-point readings: pixel voltage, pixel current and converter current. A perturb-and-observe tracker nudges a pixel-voltage reference up or down. An outer PI loop turns the gap between the pixel voltage and that reference into a current demand. A faster inner PI loop turns the gap between that demand and the converter current into a duty word. A free-running counter then turns the duty word into the gate pulse.

The inner loop runs on every strobe. The outer loop and the tracker run only on every `OUTER_DIV`-th strobe, so the current loop settles between voltage corrections. With the default 500-clock period, the switch runs at 200 kHz from a 100 MHz clock. Both integrators are bounded to their output range. The duty word is capped at 70 % of the period, which is 350 counts by default. The nominal operating point of about 1.5 V and a duty near 0.435 (about 217 counts) lies well inside that cap.

Top module: `pno_duty_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first strobe, `duty_o` is 0, `pwm_o` is low, `idem_o` is 0 and `vref_o` equals `VREF_INIT` (1500).
- R2: The inner loop updates on every strobe. The tracker and the outer loop update only on every `OUTER_DIV`-th strobe, the first being strobe number `OUTER_DIV` after reset. On other strobes `vref_o` and `idem_o` hold.
- R3: On each outer update, the power is taken as pixel voltage times pixel current. If this power is strictly greater than the power from the previous outer update, the direction of travel is kept; if it is equal or smaller, the direction is reversed. `vref_o` then moves by `STEP` (8) in the resulting direction. After reset the direction is upward and the previous power is 0.
- R4: `vref_o` is clamped to the range from `VREF_MIN` (1000) to `VREF_MAX` (2000).
- R5: The outer error is e = pixel voltage − reference, using the reference held before that same update. A pixel voltage above the reference raises the current demand. The update law is integ' = sat(integ + (e >>> OKI_SH)) and `idem_o` = sat(integ' + (e >>> OKP_SH)), where sat limits the value to the range 0 to `IDEM_MAX` (4095).
- R6: Each integrator is held within its output range. After the output has sat at its limit for many updates, a small reversed error moves the output off the limit at the very next update. Example: with `idem_o` saturated at 4095, an error of −16 gives 4085.
- R7: The inner error is e = `idem_o` − converter current, using the demand held before that same edge. It follows the same law as R5, with `IKI_SH` and `IKP_SH` and the range 0 to `DUTY_MAX`. The result becomes visible on `duty_o` at the next period boundary.
- R8: `duty_o` never exceeds `DUTY_MAX` = ⌊0.7·`PWM_PERIOD`⌋ (350), and it reaches exactly that value under a sustained large demand.
- R9: When the demand stays below the converter current, `duty_o` settles at 0 and `pwm_o` stays low for whole periods.
- R10: The PWM period is `PWM_PERIOD` clocks. `pwm_o` is high for the first `duty_o` clocks of each period and low in the last clock of each period.
- R11: `duty_o` takes a new value only at a period boundary. A command change in mid-period leaves the current pulse unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | One-cycle strobe marking a fresh set of readings |
| v_pix_i | input | DW | Pixel voltage reading, unsigned |
| i_pix_i | input | DW | Pixel current reading, unsigned |
| i_conv_i | input | DW | Converter current reading, unsigned |
| vref_o | output | DW | Pixel-voltage reference from the tracker |
| idem_o | output | IW | Current demand from the outer loop |
| duty_o | output | CW | Duty compare value applied in the current period |
| pwm_o | output | 1 | Gate drive for the flyback switch |

## Verification
The embedded properties rely on the parameters being consistent: `DUTY_MAX` lies below `PWM_PERIOD`, `STEP` is smaller than the span of the reference range, and `VREF_INIT` lies inside that range. The properties accept any strobe pattern, including back-to-back strobes. The stimulus always derives the pixel voltage from the current `vref_o` with a fixed offset of up to ±500, so the voltage words stay positive and within 12 bits. It also holds the pixel current fixed or changes it in single-count steps, so the tracker's power comparisons are exact and predictable.

// File: rtl/pno_pkg.sv
package pno_pkg;
  typedef enum logic {DIR_DN = 1'b0, DIR_UP = 1'b1} dir_e;
endpackage

// File: rtl/pno_tracker.sv
module pno_tracker import pno_pkg::*; #(
  parameter int DW        = 12,
  parameter int STEP      = 8,
  parameter int VREF_INIT = 1500,
  parameter int VREF_MIN  = 1000,
  parameter int VREF_MAX  = 2000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [DW-1:0] v_i,
  input  logic [DW-1:0] i_i,
  output logic [DW-1:0] vref_o
);
  localparam int PW = 2 * DW;
  localparam int SW = DW + 2;
  localparam logic signed [SW-1:0] STEP_S = SW'(STEP);
  localparam logic signed [SW-1:0] LO_S   = SW'(VREF_MIN);
  localparam logic signed [SW-1:0] HI_S   = SW'(VREF_MAX);
  localparam logic [DW-1:0] LO_V   = DW'(VREF_MIN);
  localparam logic [DW-1:0] HI_V   = DW'(VREF_MAX);
  localparam logic [DW-1:0] INIT_V = DW'(VREF_INIT);
  localparam logic [DW-1:0] STEP_V = DW'(STEP);

  logic [PW-1:0]        pwr, pwr_q;
  dir_e                 dir_q, dir_n;
  logic [DW-1:0]        vref_q, vref_n;
  logic signed [SW-1:0] cand;

  assign pwr = PW'(v_i) * PW'(i_i);

  always_comb begin
    // keep heading only on a strict power gain
    dir_n = (pwr > pwr_q) ? dir_q : ((dir_q == DIR_UP) ? DIR_DN : DIR_UP);
    cand  = $signed({2'b00, vref_q}) + ((dir_n == DIR_UP) ? STEP_S : -STEP_S);
    if (cand > HI_S)      vref_n = HI_V;
    else if (cand < LO_S) vref_n = LO_V;
    else                  vref_n = cand[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vref_q <= INIT_V;
      dir_q  <= DIR_UP;
      pwr_q  <= '0;
    end else if (tick_i) begin
      vref_q <= vref_n;
      dir_q  <= dir_n;
      pwr_q  <= pwr;
    end
  end

  assign vref_o = vref_q;

  AST_VREF_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vref_q >= LO_V && vref_q <= HI_V); // R4
  AST_VREF_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (vref_q - $past(vref_q) == STEP_V) || ($past(vref_q) - vref_q == STEP_V)
               || vref_q == HI_V || vref_q == LO_V); // R3
  AST_VREF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(vref_q)); // R2
endmodule

// File: rtl/pno_pi.sv
module pno_pi #(
  parameter int EW      = 13,
  parameter int OW      = 12,
  parameter int KP_SH   = 1,
  parameter int KI_SH   = 3,
  parameter int OUT_MAX = 4095
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [EW-1:0] err_i,
  output logic [OW-1:0]        out_o
);
  localparam int AW = ((EW > OW + 1) ? EW : OW + 1) + 2;
  localparam logic signed [AW-1:0] HI = AW'(OUT_MAX);

  logic signed [AW-1:0] e_x, i_sum, i_sat, o_sum, o_sat, integ_q;
  logic [OW-1:0]        out_q;

  assign e_x = AW'(err_i);

  always_comb begin
    i_sum = integ_q + (e_x >>> KI_SH);
    if (i_sum[AW-1])    i_sat = '0;
    else if (i_sum > HI) i_sat = HI;
    else                 i_sat = i_sum;
    o_sum = i_sat + (e_x >>> KP_SH);
    if (o_sum[AW-1])    o_sat = '0;
    else if (o_sum > HI) o_sat = HI;
    else                 o_sat = o_sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      integ_q <= '0;
      out_q   <= '0;
    end else if (en_i) begin
      integ_q <= i_sat;
      out_q   <= o_sat[OW-1:0];
    end
  end

  assign out_o = out_q;

  AST_INTEG_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !integ_q[AW-1] && integ_q <= HI); // R6
endmodule

// File: rtl/pno_pwm.sv
module pno_pwm #(
  parameter int PERIOD   = 500,
  parameter int CW       = 9,
  parameter int DUTY_MAX = 350
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] duty_i,
  output logic [CW-1:0] cmp_o,
  output logic          pwm_o
);
  localparam int NW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [NW-1:0] LAST = NW'(PERIOD - 1);
  localparam logic [CW-1:0] DMAX = CW'(DUTY_MAX);

  logic [NW-1:0] cnt_q, cnt_n;
  logic [CW-1:0] cmp_q, cmp_n;
  logic          pwm_q, wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    cnt_n = wrap ? '0 : cnt_q + 1'b1;
    cmp_n = wrap ? duty_i : cmp_q;  // shadow load at period end only
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cmp_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      cmp_q <= cmp_n;
      pwm_q <= (CW'(cnt_n) < cmp_n);
    end
  end

  assign cmp_o = cmp_q;
  assign pwm_o = pwm_q;

  AST_DUTY_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_q <= DMAX); // R8
  AST_CMP_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(cmp_q)); // R11
  AST_LOW_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |-> !pwm_o); // R10
endmodule

// File: rtl/pno_duty_ctrl.sv
module pno_duty_ctrl #(
  parameter int DW         = 12,
  parameter int PWM_PERIOD = 500,
  parameter int OUTER_DIV  = 4,
  parameter int STEP       = 8,
  parameter int VREF_INIT  = 1500,
  parameter int VREF_MIN   = 1000,
  parameter int VREF_MAX   = 2000,
  parameter int IDEM_MAX   = 4095,
  parameter int OKP_SH     = 1,
  parameter int OKI_SH     = 3,
  parameter int IKP_SH     = 2,
  parameter int IKI_SH     = 4,
  localparam int DUTY_MAX  = PWM_PERIOD * 7 / 10,
  localparam int CW        = $clog2(PWM_PERIOD + 1),
  localparam int IW        = $clog2(IDEM_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_i,
  input  logic [DW-1:0] v_pix_i,
  input  logic [DW-1:0] i_pix_i,
  input  logic [DW-1:0] i_conv_i,
  output logic [DW-1:0] vref_o,
  output logic [IW-1:0] idem_o,
  output logic [CW-1:0] duty_o,
  output logic          pwm_o
);
  localparam int DIVW = (OUTER_DIV > 1) ? $clog2(OUTER_DIV) : 1;
  localparam logic [DIVW-1:0] DIV_LAST = DIVW'(OUTER_DIV - 1);
  localparam int OEW = DW + 1;
  localparam int IEW = ((IW > DW) ? IW : DW) + 1;

  logic [DIVW-1:0]       div_q;
  logic                  outer_tick;
  logic [DW-1:0]         vref;
  logic [IW-1:0]         idem;
  logic [CW-1:0]         duty_cmd;
  logic signed [OEW-1:0] o_err;
  logic signed [IEW-1:0] i_err;

  assign outer_tick = sample_i && (div_q == DIV_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         div_q <= '0;
    else if (outer_tick) div_q <= '0;
    else if (sample_i)   div_q <= div_q + 1'b1;
  end

  pno_tracker #(
    .DW(DW), .STEP(STEP), .VREF_INIT(VREF_INIT),
    .VREF_MIN(VREF_MIN), .VREF_MAX(VREF_MAX)
  ) u_trk (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(outer_tick),
    .v_i(v_pix_i), .i_i(i_pix_i), .vref_o(vref)
  );

  // pixel above reference -> draw more current
  assign o_err = $signed({1'b0, v_pix_i}) - $signed({1'b0, vref});

  pno_pi #(
    .EW(OEW), .OW(IW), .KP_SH(OKP_SH), .KI_SH(OKI_SH), .OUT_MAX(IDEM_MAX)
  ) u_outer (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(outer_tick),
    .err_i(o_err), .out_o(idem)
  );

  assign i_err = $signed(IEW'(idem)) - $signed(IEW'(i_conv_i));

  pno_pi #(
    .EW(IEW), .OW(CW), .KP_SH(IKP_SH), .KI_SH(IKI_SH), .OUT_MAX(DUTY_MAX)
  ) u_inner (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(sample_i),
    .err_i(i_err), .out_o(duty_cmd)
  );

  pno_pwm #(
    .PERIOD(PWM_PERIOD), .CW(CW), .DUTY_MAX(DUTY_MAX)
  ) u_pwm (
    .clk_i(clk_i), .rst_ni(rst_ni), .duty_i(duty_cmd),
    .cmp_o(duty_o), .pwm_o(pwm_o)
  );

  assign vref_o = vref;
  assign idem_o = idem;

  AST_OUTER_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !outer_tick) |=> $stable(idem)); // R2
  AST_NO_STROBE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(idem) && $stable(vref)); // R2
endmodule

// File: tb/sim_pno_duty_ctrl.sv
module sim_pno_duty_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD = 500;
  localparam int DIV    = 4;
  localparam int STEP   = 8;
  localparam int VINIT  = 1500;
  localparam int VMIN   = 1000;
  localparam int VMAX   = 2000;
  localparam int IMAX   = 4095;
  localparam int DMAX   = 350;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample = 1'b0;
  logic [11:0] v_pix = '0, i_pix = '0, i_conv = '0;
  logic [11:0] vref, idem;
  logic [8:0]  duty;
  logic        pwm;

  int nchk = 0;
  int nerr = 0;
  int vm, pm;
  bit up;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pno_duty_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample),
    .v_pix_i(v_pix), .i_pix_i(i_pix), .i_conv_i(i_conv),
    .vref_o(vref), .idem_o(idem), .duty_o(duty), .pwm_o(pwm)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sat(input int x, input int hi);
    return (x < 0) ? 0 : ((x > hi) ? hi : x);
  endfunction

  task automatic strobe();
    @(negedge clk); sample = 1'b1;
    @(negedge clk); sample = 1'b0;
  endtask

  task automatic tick();
    repeat (DIV) strobe();
  endtask

  task automatic count_high(output int n);
    n = 0;
    for (int k = 0; k < PERIOD; k++) begin
      n += int'(pwm);
      @(negedge clk);
    end
  endtask

  task automatic align();
    while (pwm !== 1'b0) @(negedge clk);
    while (pwm !== 1'b1) @(negedge clk);
  endtask

  task automatic t_reset();
    sample = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(duty == 0 && pwm == 0, "R1 duty/pwm in reset", int'(duty), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(vref == 12'(VINIT), "R1 vref after reset", int'(vref), VINIT);
    chk(idem == 0, "R1 idem after reset", int'(idem), 0);
    chk(duty == 0 && pwm == 0, "R1 duty/pwm after reset", int'(duty), 0);
    vm = VINIT; pm = 0; up = 1'b1;
  endtask

  // one tracker update against the R3/R4 model
  task automatic pno_step(input int v, input int i, input string tag);
    int p;
    v_pix = 12'(v); i_pix = 12'(i);
    tick();
    p = v * i;
    if (!(p > pm)) up = !up;
    vm = up ? vm + STEP : vm - STEP;
    if (vm > VMAX) vm = VMAX;
    if (vm < VMIN) vm = VMIN;
    pm = p;
    chk(int'(vref) == vm, tag, int'(vref), vm);
  endtask

  task automatic t_rate_and_law();
    int e, ig, exp_id, exp_d;
    t_reset();
    v_pix = 12'd1540; i_pix = 12'd100; i_conv = '0;
    for (int s = 1; s < DIV; s++) begin
      strobe();
      chk(idem == 0, "R2 idem holds before Nth strobe", int'(idem), 0);
      chk(vref == 12'(VINIT), "R2 vref holds before Nth strobe", int'(vref), VINIT);
    end
    strobe();
    chk(vref == 12'(VINIT + STEP), "R3 first update moves up", int'(vref), VINIT + STEP);
    e = 1540 - VINIT;
    ig = sat(e >>> 3, IMAX);
    exp_id = sat(ig + (e >>> 1), IMAX);
    chk(int'(idem) == exp_id, "R5 outer law first update", int'(idem), exp_id);
    strobe();
    exp_d = sat(sat(exp_id >>> 4, DMAX) + (exp_id >>> 2), DMAX);
    repeat (2 * PERIOD) @(negedge clk);
    chk(int'(duty) == exp_d, "R7 inner law first update", int'(duty), exp_d);
    v_pix = 12'd1600;
    for (int s = 1; s < DIV - 1; s++) begin
      strobe();
      chk(int'(idem) == exp_id, "R2 idem holds mid window", int'(idem), exp_id);
    end
    strobe();
    e = 1600 - (VINIT + STEP);
    ig = sat(ig + (e >>> 3), IMAX);
    exp_id = sat(ig + (e >>> 1), IMAX);
    chk(int'(idem) == exp_id, "R2 R5 second outer update", int'(idem), exp_id);
  endtask

  task automatic t_pno_track();
    t_reset();
    pno_step(1600, 100, "R3 rise from zero keeps up");
    pno_step(1600, 101, "R3 gain keeps direction");
    pno_step(1600, 100, "R3 loss reverses");
    pno_step(1600, 100, "R3 equal power reverses");
    pno_step(1600, 100, "R3 equal power reverses again");
    pno_step(1600, 120, "R3 gain keeps direction down");
    pno_step(1600, 90,  "R3 loss reverses to up");
  endtask

  task automatic t_vref_clamp();
    int i;
    t_reset();
    i = 100;
    for (int n = 0; n < 70; n++) begin
      pno_step(1600, i, "R4 upward run");
      chk(int'(vref) <= VMAX, "R4 upper bound", int'(vref), VMAX);
      i++;
    end
    chk(int'(vref) == VMAX, "R4 pinned at max", int'(vref), VMAX);
    i--;
    pno_step(1600, i - 1, "R3 reverse at max");
    for (int n = 0; n < 130; n++) begin
      pno_step(1600, i, "R4 downward run");
      chk(int'(vref) >= VMIN, "R4 lower bound", int'(vref), VMIN);
      i++;
    end
    chk(int'(vref) == VMIN, "R4 pinned at min", int'(vref), VMIN);
  endtask

  task automatic t_windup();
    t_reset();
    i_pix = 12'd100; i_conv = '0;
    for (int n = 0; n < 100; n++) begin
      v_pix = vref + 12'd500;
      tick();
    end
    chk(int'(idem) == IMAX, "R5 demand saturates", int'(idem), IMAX);
    v_pix = vref - 12'd16;
    tick();
    chk(int'(idem) == IMAX + (-16 >>> 3) + (-16 >>> 1), "R6 leaves limit at once",
        int'(idem), IMAX + (-16 >>> 3) + (-16 >>> 1));
  endtask

  task automatic t_duty_ceiling();
    t_reset();
    i_pix = 12'd100; i_conv = '0;
    for (int n = 0; n < 100; n++) begin
      v_pix = vref + 12'd500;
      tick();
      chk(int'(duty) <= DMAX, "R8 duty under cap", int'(duty), DMAX);
    end
    repeat (2 * PERIOD) @(negedge clk);
    chk(int'(duty) == DMAX, "R8 duty at cap", int'(duty), DMAX);
  endtask

  task automatic t_pwm_boundary();
    int n0, n1, d1, mid;
    align();
    v_pix = vref - 12'd500;
    i_conv = 12'd4095;
    n0 = 0; mid = -1;
    for (int k = 0; k < PERIOD; k++) begin
      n0 += int'(pwm);
      if (k == 150) mid = int'(duty);
      sample = (k >= 100 && k < 100 + 4 * DIV && (k % 2) == 0);
      @(negedge clk);
    end
    sample = 1'b0;
    chk(mid == DMAX, "R11 duty held mid period", mid, DMAX);
    chk(n0 == DMAX, "R11 pulse kept old width", n0, DMAX);
    d1 = int'(duty);
    chk(d1 < DMAX, "R11 new duty at boundary", d1, DMAX - 1);
    count_high(n1);
    chk(n1 == d1, "R10 high time equals duty", n1, d1);
    chk(int'(duty) == d1, "R11 duty stable over period", int'(duty), d1);
  endtask

  task automatic t_duty_floor();
    int n;
    i_conv = 12'd4095;
    for (int k = 0; k < 150; k++) begin
      v_pix = vref - 12'd500;
      tick();
    end
    repeat (2 * PERIOD) @(negedge clk);
    chk(duty == 0, "R9 duty at floor", int'(duty), 0);
    count_high(n);
    chk(n == 0, "R9 pwm low whole period", n, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_rate_and_law();
    t_pno_track();
    t_vref_clamp();
    t_windup();
    t_duty_ceiling();
    t_pwm_boundary();
    t_duty_floor();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule